// File: doc/BRIEF.md
# Storage Port Interrupt Status Register

This block holds the 32-bit interrupt status word of one port of a serial storage host controller. The link, transport and DMA logic send it single-cycle event pulses. It qualifies each pulse, for example by a capability input, by an error bit, or by whether the link error hit a data FIS, and latches the result into a sticky status bit. Software reads the word through a plain register port and clears latched bits by writing ones to them. Three bits are live copies of external level inputs and cannot be written. The reserved bits and the host bus data error bit always read zero.

The block also drives a registered port interrupt request. This is the OR of the status word masked by a 32-bit enable input. It also keeps a DMA fatal-halt flag. The interface-fatal and overflow errors set this flag. Only the command-start input dropping, a port reset or a global reset release it. There is no streaming data path here: every pin is a plain control or status level, sampled on the rising clock edge.

Top module: `port_irq_status`

## Requirements
- R1: While `rst_n` is low, and after it is released with no events, `reg_rdata` (mirror inputs low), `irq` and `dma_fatal` are all 0.
- R2: Writing (`reg_wr`=1) a word with a 1 in a latched bit position clears that bit, and a 0 leaves it unchanged. If a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R3: Bits 28, 25 and 21..8 always read 0. Bits 22, 6 and 4 read the live levels of `phy_rdy_chg`, `conn_chg` and `unk_fis_pend`. Writes do not affect these bits, and pulses on `evt_low[6]` and `evt_low[4]` have no effect.
- R4: Bit 31 sets on `evt_cold_presence` only when `cap_cold_detect` is 1.
- R5: Bit 30 sets on `evt_tf_update` only when `tf_err_bit` is 1.
- R6: Each of these is a direct event that sets its own bit on the clock edge after the pulse: `evt_bus_err_resp` sets bit 29, `evt_overflow` sets bit 24, `evt_pm_mismatch` sets bit 23, and `evt_low[n]` sets bit n for n in 7, 5, 3, 2, 1, 0.
- R7: Bit 27 sets on any of these: `evt_sync_escape`; any bit of `link_err` (protocol, CRC, handshake, PHY-not-ready) while `link_in_data_fis`=1; `evt_long_unknown_fis`; `evt_prd_zero_count`.
- R8: Bit 26 sets on any `link_err` bit while `link_in_data_fis`=0, or on `evt_read_underflow`. Neither of these sets bit 27.
- R9: `dma_fatal` rises on the edge where bit 27 or bit 24 sets, provided `cmd_start`=1 and `port_rst`=0. It stays high when those status bits are cleared. It goes low on the first edge with `cmd_start`=0 or `port_rst`=1, and this release takes priority over a new event.
- R10: `irq` equals the OR of (read value AND `irq_en`) sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| port_rst | input | 1 | Port reset, releases the fatal flag |
| cmd_start | input | 1 | Command engine running; low releases the fatal flag |
| cap_cold_detect | input | 1 | Cold presence detection supported |
| evt_cold_presence | input | 1 | Cold presence input changed (pulse) |
| evt_tf_update | input | 1 | Device updated task-file status (pulse) |
| tf_err_bit | input | 1 | Error bit (bit 0) of the new task-file status |
| evt_bus_err_resp | input | 1 | Bus master saw an ERROR response (pulse) |
| evt_sync_escape | input | 1 | SYNC escape during host-to-device register or data FIS (pulse) |
| link_err | input | 4 | Protocol, CRC, handshake, PHY-not-ready error pulses |
| link_in_data_fis | input | 1 | Qualifies link_err: 1 = data FIS, 0 = non-data FIS |
| evt_long_unknown_fis | input | 1 | Unknown FIS with good CRC over 64 bytes (pulse) |
| evt_prd_zero_count | input | 1 | Descriptor entry with zero byte count (pulse) |
| evt_read_underflow | input | 1 | Command list underflow on DMA read (pulse) |
| evt_overflow | input | 1 | Command list overflow (pulse) |
| evt_pm_mismatch | input | 1 | FIS with unexpected port multiplier field (pulse) |
| evt_low | input | 8 | Low-byte event pulses; bits 6 and 4 ignored |
| phy_rdy_chg | input | 1 | Live level mirrored on bit 22 |
| conn_chg | input | 1 | Live level mirrored on bit 6 |
| unk_fis_pend | input | 1 | Live level mirrored on bit 4 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; ones clear latched bits |
| irq_en | input | 32 | Per-bit interrupt enable |
| reg_rdata | output | 32 | Current status word |
| irq | output | 1 | Registered port interrupt request |
| dma_fatal | output | 1 | Sticky DMA fatal-halt flag |

## Verification
The assertions assume that every event input is a synchronous pulse sampled only at the rising edge. They also assume that the mirror level inputs are held low while `rst_n` is low, so the interrupt register and the status word agree on the first edge after reset. The bench drives all inputs on the falling edge and keeps the mirrors and the enable at 0 during reset. Its random phase gives each event a low firing rate, so latched bits live long enough for clearing writes, set-versus-clear collisions and the fatal release paths to be exercised.

// File: rtl/pisr_pkg.sv
package pisr_pkg;
  localparam int REG_W = 32;
  localparam int LINK_ERR_W = 4;
  localparam int LOW_W = 8;

  localparam int B_COLD = 31;
  localparam int B_TFE  = 30;
  localparam int B_HBF  = 29;
  localparam int B_IFF  = 27;
  localparam int B_INF  = 26;
  localparam int B_OVF  = 24;
  localparam int B_PMM  = 23;
  localparam int B_PRC  = 22;
  localparam int B_CONN = 6;
  localparam int B_UFIS = 4;

  localparam logic [REG_W-1:0] LATCH_MASK  = 32'hED80_00AF;
  localparam logic [REG_W-1:0] MIRROR_MASK = 32'h0040_0050;
  localparam logic [LOW_W-1:0] LOW_EVT_MASK = LATCH_MASK[LOW_W-1:0];
endpackage

// File: rtl/pisr_event_qual.sv
module pisr_event_qual
  import pisr_pkg::*;
#(
  parameter int W = REG_W,
  parameter int LEW = LINK_ERR_W,
  parameter int LW = LOW_W
) (
  input  logic           cap_cold_detect,
  input  logic           evt_cold_presence,
  input  logic           evt_tf_update,
  input  logic           tf_err_bit,
  input  logic           evt_bus_err_resp,
  input  logic           evt_sync_escape,
  input  logic [LEW-1:0] link_err,
  input  logic           link_in_data_fis,
  input  logic           evt_long_unknown_fis,
  input  logic           evt_prd_zero_count,
  input  logic           evt_read_underflow,
  input  logic           evt_overflow,
  input  logic           evt_pm_mismatch,
  input  logic [LW-1:0]  evt_low,
  output logic [W-1:0]   set_vec
);
  logic any_link_err;
  assign any_link_err = |link_err;

  always_comb begin
    set_vec = '0;
    set_vec[B_COLD] = evt_cold_presence & cap_cold_detect;
    set_vec[B_TFE]  = evt_tf_update & tf_err_bit;
    set_vec[B_HBF]  = evt_bus_err_resp;
    set_vec[B_IFF]  = evt_sync_escape | (any_link_err & link_in_data_fis)
                    | evt_long_unknown_fis | evt_prd_zero_count;
    set_vec[B_INF]  = (any_link_err & ~link_in_data_fis) | evt_read_underflow;
    set_vec[B_OVF]  = evt_overflow;
    set_vec[B_PMM]  = evt_pm_mismatch;
    set_vec[LW-1:0] = evt_low & LOW_EVT_MASK;
  end
endmodule

// File: rtl/pisr_status_bits.sv
module pisr_status_bits
  import pisr_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [W-1:0] LMASK = LATCH_MASK,
  parameter logic [W-1:0] MMASK = MIRROR_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] mirror_vec,
  output logic [W-1:0] rd_vec
);
  logic [W-1:0] latched;
  logic [W-1:0] clr_vec;

  assign clr_vec = wr ? wdata : '0;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latched <= '0;
    else        latched <= (set_vec | (latched & ~clr_vec)) & LMASK;
  end

  assign rd_vec = latched | (mirror_vec & MMASK);
endmodule

// File: rtl/pisr_fatal_latch.sv
module pisr_fatal_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic port_rst,
  input  logic cmd_start,
  input  logic fatal_evt,
  output logic fatal
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     fatal <= 1'b0;
    else if (!cmd_start || port_rst) fatal <= 1'b0;
    else if (fatal_evt)             fatal <= 1'b1;
  end
endmodule

// File: rtl/port_irq_status.sv
module port_irq_status
  import pisr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  port_rst,
  input  logic                  cmd_start,
  input  logic                  cap_cold_detect,
  input  logic                  evt_cold_presence,
  input  logic                  evt_tf_update,
  input  logic                  tf_err_bit,
  input  logic                  evt_bus_err_resp,
  input  logic                  evt_sync_escape,
  input  logic [LINK_ERR_W-1:0] link_err,
  input  logic                  link_in_data_fis,
  input  logic                  evt_long_unknown_fis,
  input  logic                  evt_prd_zero_count,
  input  logic                  evt_read_underflow,
  input  logic                  evt_overflow,
  input  logic                  evt_pm_mismatch,
  input  logic [LOW_W-1:0]      evt_low,
  input  logic                  phy_rdy_chg,
  input  logic                  conn_chg,
  input  logic                  unk_fis_pend,
  input  logic                  reg_wr,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic [REG_W-1:0]      irq_en,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  irq,
  output logic                  dma_fatal
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] mirror_vec;

  pisr_event_qual u_qual (
    .cap_cold_detect      (cap_cold_detect),
    .evt_cold_presence    (evt_cold_presence),
    .evt_tf_update        (evt_tf_update),
    .tf_err_bit           (tf_err_bit),
    .evt_bus_err_resp     (evt_bus_err_resp),
    .evt_sync_escape      (evt_sync_escape),
    .link_err             (link_err),
    .link_in_data_fis     (link_in_data_fis),
    .evt_long_unknown_fis (evt_long_unknown_fis),
    .evt_prd_zero_count   (evt_prd_zero_count),
    .evt_read_underflow   (evt_read_underflow),
    .evt_overflow         (evt_overflow),
    .evt_pm_mismatch      (evt_pm_mismatch),
    .evt_low              (evt_low),
    .set_vec              (set_vec)
  );

  always_comb begin
    mirror_vec = '0;
    mirror_vec[B_PRC]  = phy_rdy_chg;
    mirror_vec[B_CONN] = conn_chg;
    mirror_vec[B_UFIS] = unk_fis_pend;
  end

  pisr_status_bits u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .wr         (reg_wr),
    .wdata      (reg_wdata),
    .mirror_vec (mirror_vec),
    .rd_vec     (reg_rdata)
  );

  pisr_fatal_latch u_fatal (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_rst  (port_rst),
    .cmd_start (cmd_start),
    .fatal_evt (set_vec[B_IFF] | set_vec[B_OVF]),
    .fatal     (dma_fatal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(reg_rdata & irq_en);
  end
endmodule

// File: rtl/pisr_checker.sv
module pisr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        port_rst,
  input logic        cmd_start,
  input logic        cap_cold_detect,
  input logic        evt_tf_update,
  input logic        tf_err_bit,
  input logic        evt_overflow,
  input logic        phy_rdy_chg,
  input logic [31:0] irq_en,
  input logic [31:0] reg_rdata,
  input logic        irq,
  input logic        dma_fatal
);
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[28] == 1'b0 && reg_rdata[25] == 1'b0 && reg_rdata[21:8] == 14'd0);

  p_phy_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[22] == phy_rdy_chg);

  p_cold_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_cold_detect && !reg_rdata[31] |=> !reg_rdata[31]);

  p_tfe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[30] && !(evt_tf_update && tf_err_bit) |=> !reg_rdata[30]);

  p_ovf_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |=> reg_rdata[24]);

  p_fatal_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow && cmd_start && !port_rst |=> dma_fatal);

  p_fatal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_fatal && cmd_start && !port_rst |=> dma_fatal);

  p_fatal_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_start || port_rst |=> !dma_fatal);

  p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq == $past(|(reg_rdata & irq_en)));
endmodule

bind port_irq_status pisr_checker i_chk (.*);

// File: tb/test_port_irq_status.sv
module test_port_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_rst, cmd_start, cap_cold_detect, evt_cold_presence, evt_tf_update;
  logic tf_err_bit, evt_bus_err_resp, evt_sync_escape, link_in_data_fis;
  logic evt_long_unknown_fis, evt_prd_zero_count, evt_read_underflow;
  logic evt_overflow, evt_pm_mismatch, phy_rdy_chg, conn_chg, unk_fis_pend, reg_wr;
  logic [3:0]  link_err;
  logic [7:0]  evt_low;
  logic [31:0] reg_wdata, irq_en, reg_rdata;
  logic irq, dma_fatal;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_q = '0;
  logic m_irq = 1'b0;
  logic m_fatal = 1'b0;

  always #4 clk = ~clk;

  port_irq_status i_port_irq_status (.*);

  function automatic logic [31:0] f_set();
    logic [31:0] s = '0;
    s[31] = evt_cold_presence & cap_cold_detect;
    s[30] = evt_tf_update & tf_err_bit;
    s[29] = evt_bus_err_resp;
    s[27] = evt_sync_escape | ((|link_err) & link_in_data_fis)
          | evt_long_unknown_fis | evt_prd_zero_count;
    s[26] = ((|link_err) & ~link_in_data_fis) | evt_read_underflow;
    s[24] = evt_overflow;
    s[23] = evt_pm_mismatch;
    s[7] = evt_low[7]; s[5] = evt_low[5]; s[3:0] = evt_low[3:0];
    return s;
  endfunction

  function automatic logic [31:0] f_read(logic [31:0] q);
    logic [31:0] r = q;
    r[22] = phy_rdy_chg; r[6] = conn_chg; r[4] = unk_fis_pend;
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clr_pulses();
    evt_cold_presence = 0; evt_tf_update = 0; evt_bus_err_resp = 0;
    evt_sync_escape = 0; link_err = '0; evt_long_unknown_fis = 0;
    evt_prd_zero_count = 0; evt_read_underflow = 0; evt_overflow = 0;
    evt_pm_mismatch = 0; evt_low = '0; reg_wr = 0; reg_wdata = '0;
  endtask

  // inputs already driven; advance one edge and compare with the model
  task automatic step(string tag);
    logic [31:0] s, nq;
    logic ni, nf;
    s  = f_set();
    nq = s | (m_q & ~(reg_wr ? reg_wdata : 32'd0));
    ni = |(f_read(m_q) & irq_en);
    nf = (!cmd_start || port_rst) ? 1'b0 : (m_fatal | s[27] | s[24]);
    @(posedge clk);
    m_q = nq; m_irq = ni; m_fatal = nf;
    @(negedge clk);
    chk(tag, "rdata", reg_rdata, f_read(m_q));
    chk(tag, "irq", {31'd0, irq}, {31'd0, m_irq});
    chk(tag, "fatal", {31'd0, dma_fatal}, {31'd0, m_fatal});
    clr_pulses();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clr_pulses();
    port_rst = 0; cmd_start = 1; cap_cold_detect = 0; tf_err_bit = 0;
    link_in_data_fis = 0; phy_rdy_chg = 0; conn_chg = 0; unk_fis_pend = 0;
    irq_en = '0;
    repeat (3) @(negedge clk);
    chk("R1", "rdata in reset", reg_rdata, 32'd0);
    chk("R1", "irq in reset", {31'd0, irq}, 32'd0);
    chk("R1", "fatal in reset", {31'd0, dma_fatal}, 32'd0);
    rst_n = 1;
    step("R1");

    evt_cold_presence = 1; step("R4");
    cap_cold_detect = 1; evt_cold_presence = 1; step("R4");
    evt_tf_update = 1; tf_err_bit = 0; step("R5");
    evt_tf_update = 1; tf_err_bit = 1; step("R5");

    reg_wr = 1; reg_wdata = 32'h0; step("R2");
    reg_wr = 1; reg_wdata = 32'h8000_0000; step("R2");
    chk("R2", "bit31 cleared", {31'd0, reg_rdata[31]}, 32'd0);
    evt_bus_err_resp = 1; reg_wr = 1; reg_wdata = 32'h2000_0000; step("R2");
    chk("R2", "set wins", {31'd0, reg_rdata[29]}, 32'd1);

    evt_pm_mismatch = 1; evt_low = 8'hFF; step("R6");
    chk("R6", "low events, 6/4 ignored", {24'd0, reg_rdata[7:0]}, 32'h0000_00AF);

    link_err = 4'b0010; link_in_data_fis = 0; step("R8");
    chk("R8", "non-data link err no fatal bit", {31'd0, reg_rdata[27]}, 32'd0);
    evt_read_underflow = 1; step("R8");

    link_err = 4'b0100; link_in_data_fis = 1; step("R7");
    chk("R9", "fatal from bit27", {31'd0, dma_fatal}, 32'd1);
    reg_wr = 1; reg_wdata = 32'h0900_0000; step("R9");
    chk("R9", "fatal held after clear", {31'd0, dma_fatal}, 32'd1);
    cmd_start = 0; step("R9");
    cmd_start = 1; evt_sync_escape = 1; step("R7");
    port_rst = 1; step("R9");
    port_rst = 0; evt_long_unknown_fis = 1; step("R7");
    cmd_start = 0; evt_prd_zero_count = 1; step("R9");
    cmd_start = 1; evt_overflow = 1; step("R9");

    phy_rdy_chg = 1; conn_chg = 1; unk_fis_pend = 1; step("R3");
    reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; step("R3");
    chk("R3", "mirrors survive write", reg_rdata & 32'h0040_0050, 32'h0040_0050);
    phy_rdy_chg = 0; step("R3");

    irq_en = 32'h0000_0040; step("R10");
    step("R10");
    conn_chg = 0; step("R10");
    step("R10");

    for (int i = 0; i < 4000; i++) begin
      cap_cold_detect   = $urandom_range(0, 1);
      evt_cold_presence = ($urandom_range(0, 15) == 0);
      evt_tf_update     = ($urandom_range(0, 15) == 0);
      tf_err_bit        = $urandom_range(0, 1);
      evt_bus_err_resp  = ($urandom_range(0, 31) == 0);
      evt_sync_escape   = ($urandom_range(0, 63) == 0);
      link_err          = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'd0;
      link_in_data_fis  = $urandom_range(0, 1);
      evt_long_unknown_fis = ($urandom_range(0, 63) == 0);
      evt_prd_zero_count   = ($urandom_range(0, 63) == 0);
      evt_read_underflow   = ($urandom_range(0, 31) == 0);
      evt_overflow      = ($urandom_range(0, 63) == 0);
      evt_pm_mismatch   = ($urandom_range(0, 31) == 0);
      evt_low           = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'd0;
      phy_rdy_chg       = ($urandom_range(0, 7) == 0);
      conn_chg          = ($urandom_range(0, 7) == 0);
      unk_fis_pend      = ($urandom_range(0, 7) == 0);
      reg_wr            = ($urandom_range(0, 3) == 0);
      reg_wdata         = $urandom;
      irq_en            = ($urandom_range(0, 1) == 0) ? $urandom : 32'd0;
      cmd_start         = ($urandom_range(0, 31) != 0);
      port_rst          = ($urandom_range(0, 63) == 0);
      step("R2/R6/R7/R8/R9/R10");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule